// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Target Protocol Engine

This block is the bus-facing half of a 256-byte serial EEPROM. It oversamples the two bus wires on the system clock and finds start and stop conditions. It shifts in header, word-address and data bytes and acknowledges each one on the ninth clock. Read data goes out MSB first. The engine holds the address pointer that current, random and sequential reads use. Write bytes go to a page buffer as one-cycle strobes. Decisions on the write-protect control code come from a separate protect controller, which sees the header byte while the engine waits in the acknowledge phase.

The engine does not drive the data wire directly. It raises an open-drain enable, and the pad pulls the line low while that enable is high. Three strap inputs set the target's sub-address. While a write cycle is pending the engine answers no header, so the master can poll with headers until an acknowledge comes back.

Top module: `eeprom_tgt_engine`

## Requirements
- R1: A falling SDA while SCL is high is a start, and it restarts header reception from bit zero. This holds even in the middle of a byte. A rising SDA while SCL is high is a stop: it releases SDA, returns the engine to idle, and pulses `stop_pulse` exactly once.
- R2: A header whose upper nibble is 4'b1010 and whose bits [3:1] equal `dev_pins` is acknowledged. Bit 0 is the direction, and 1 means read. A header with other pins is not acknowledged, and the engine goes idle.
- R3: Each accepted received byte is acknowledged by holding SDA low for the whole ninth SCL clock. SDA is released after that clock falls.
- R4: Read bytes are driven MSB first. Each bit changes only after a falling SCL edge.
- R5: The second byte of a write loads the pointer. Each data byte after it produces one `wb_valid` strobe that carries the pointer and the byte.
- R6: During a write, the pointer's low 4 bits step and wrap inside the 16-byte page. The upper bits do not change.
- R7: A read header with no preceding address returns the byte at the pointer, which is the last accessed address plus one. The pointer keeps its value across transactions.
- R8: A random read works as follows: a write header and a word address, then a repeated start, then a read header. It returns the byte at that word address.
- R9: In a read, each returned byte advances the pointer, and 0xFF wraps to 0x00. A master acknowledge continues with the next byte. A master non-acknowledge ends the read.
- R10: While `cycle_busy` is high, no header is acknowledged.
- R11: A header with upper nibble 4'b0110 is acknowledged only when `hdr_ok` is high. Bytes written under it produce no `wb_valid`. Reads under it return 0xFF and leave the pointer unchanged.
- R12: After reset, SDA is released, no write strobe is active and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire |
| sda_i | input | 1 | Bus data wire as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |
| dev_pins | input | 3 | Strapped sub-address |
| cycle_busy | input | 1 | Internal write cycle pending |
| hdr_ok | input | 1 | Protect controller accepts the protect-code header |
| hdr_pend | output | 1 | A received header is awaiting its ack decision |
| hdr_byte | output | 8 | Last received header byte |
| wb_valid | output | 1 | Write byte strobe to the page buffer |
| wb_addr | output | 8 | Address of the write byte |
| wb_data | output | 8 | Write byte |
| mem_raddr | output | 8 | Array read address (the pointer) |
| mem_rdata | input | 8 | Array read data, combinational from mem_raddr |
| stop_pulse | output | 1 | One-cycle pulse on each stop |

## Verification
A repeated start and the bit shifter can fall in the same window. The start arrives while the engine sits in the data-receive state right after a word-address acknowledge, and it must take priority over shifting a bit. This is provoked by the random reads and by a start inserted after four header bits. It is judged by the acknowledge of the following header and by the byte returned. The pointer advance on a read's final byte and its wrap at 0xFF also coincide. The bench judges this with a current-address read directly after a read that crosses the top of the array.

// File: rtl/eeprom_eng_pkg.sv
package eeprom_eng_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WA, S_WA_ACK, S_WD, S_WD_ACK, S_RD, S_RACK, S_RLOAD
  } eng_state_t;

  localparam logic [3:0] CODE_ARRAY = 4'b1010;
  localparam logic [3:0] CODE_PROT  = 4'b0110;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/addr_ptr.sv
module addr_ptr #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          wr_adv,
  input  logic          rd_adv,
  output logic [AW-1:0] ptr
);
  function automatic logic [AW-1:0] page_next(logic [AW-1:0] a);
    logic [PAGE_BITS-1:0] lo;
    lo = a[PAGE_BITS-1:0] + 1'b1;
    return {a[AW-1:PAGE_BITS], lo};
  endfunction

  function automatic logic [AW-1:0] seq_next(logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_val;
    else if (wr_adv) ptr <= page_next(ptr);
    else if (rd_adv) ptr <= seq_next(ptr);
  end

  // R9: full-array wrap on reads
  p_read_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !load && !wr_adv && ptr == '1) |=> (ptr == '0));

  // R6: page row kept during writes
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv && !load) |=> (ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS])));
endmodule

// File: rtl/eeprom_tgt_engine.sv
module eeprom_tgt_engine
  import eeprom_eng_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_BITS   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    dev_pins,
  input  logic          cycle_busy,
  input  logic          hdr_ok,
  output logic          hdr_pend,
  output logic [DW-1:0] hdr_byte,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          stop_pulse
);
  localparam int BCW = $clog2(DW + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eng_state_t     st;
  logic [BCW-1:0] bitn;
  logic [DW-1:0]  sh;
  logic           ack_half, rw_q, prot_q;
  logic [AW-1:0]  ptr;

  // named internal events
  logic          in_rx, in_ack, byte_in_done, hdr_accept, do_ack;
  logic          ld_ptr, wr_adv, rd_adv;
  logic [DW-1:0] byte_now, rd_byte;

  assign byte_now     = {sh[DW-2:0], sda_s};
  assign in_rx        = (st == S_DEV) || (st == S_WA) || (st == S_WD);
  assign in_ack       = (st == S_DEV_ACK) || (st == S_WA_ACK) || (st == S_WD_ACK);
  assign byte_in_done = in_rx && scl_rise && (bitn == BCW'(DW - 1));
  assign hdr_accept   = !cycle_busy &&
                        (((sh[7:4] == CODE_ARRAY) && (sh[3:1] == dev_pins)) ||
                         ((sh[7:4] == CODE_PROT) && hdr_ok));
  assign do_ack       = (st == S_DEV_ACK) ? hdr_accept : 1'b1;
  assign ld_ptr       = byte_in_done && (st == S_WA) && !prot_q;
  assign wr_adv       = byte_in_done && (st == S_WD) && !prot_q;
  assign rd_adv       = scl_rise && (st == S_RACK) && !prot_q;
  assign rd_byte      = prot_q ? '1 : mem_rdata;

  assign hdr_pend  = (st == S_DEV_ACK) && !ack_half;
  assign hdr_byte  = sh;
  assign mem_raddr = ptr;

  addr_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ld_ptr), .load_val(AW'(byte_now)),
    .wr_adv(wr_adv), .rd_adv(rd_adv), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitn <= '0; sh <= '0; sda_oe <= 1'b0;
      ack_half <= 1'b0; rw_q <= 1'b0; prot_q <= 1'b0;
      wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0; stop_pulse <= 1'b0;
    end else begin
      wb_valid   <= wr_adv;
      stop_pulse <= stop_ev;
      if (wr_adv) begin
        wb_addr <= ptr;
        wb_data <= byte_now;
      end
      if (start_ev) begin
        st <= S_DEV; bitn <= '0; sda_oe <= 1'b0; ack_half <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_oe <= 1'b0; ack_half <= 1'b0;
      end else begin
        case (st)
          S_DEV, S_WA, S_WD: if (scl_rise) begin
            sh <= byte_now;
            if (bitn == BCW'(DW - 1)) begin
              bitn <= '0;
              st   <= (st == S_DEV) ? S_DEV_ACK : (st == S_WA) ? S_WA_ACK : S_WD_ACK;
            end else bitn <= bitn + 1'b1;
          end
          S_DEV_ACK, S_WA_ACK, S_WD_ACK: if (scl_fall) begin
            if (!ack_half) begin
              if (do_ack) begin
                sda_oe   <= 1'b1;
                ack_half <= 1'b1;
                if (st == S_DEV_ACK) begin
                  rw_q   <= sh[0];
                  prot_q <= (sh[7:4] == CODE_PROT);
                end
              end else st <= S_IDLE;
            end else begin
              ack_half <= 1'b0;
              if (st == S_DEV_ACK && rw_q) begin
                sh     <= rd_byte;
                sda_oe <= !rd_byte[DW-1];
                bitn   <= '0;
                st     <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= (st == S_DEV_ACK) ? S_WA : S_WD;
              end
            end
          end
          S_RD: begin
            if (scl_rise) bitn <= bitn + 1'b1;
            else if (scl_fall) begin
              if (bitn == BCW'(DW)) begin
                sda_oe <= 1'b0; bitn <= '0; st <= S_RACK;
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= !sh[DW-2];
              end
            end
          end
          S_RACK:  if (scl_rise) st <= sda_s ? S_IDLE : S_RLOAD;
          S_RLOAD: if (scl_fall) begin
            sh <= rd_byte; sda_oe <= !rd_byte[DW-1]; st <= S_RD;
          end
          default: ;
        endcase
      end
    end
  end

  // R1: stop releases the line
  p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
  // R1: start restarts header reception
  p_restart_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == S_DEV && bitn == '0));
  // R10: busy headers get no ack
  p_busy_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV_ACK && scl_fall && !ack_half && cycle_busy) |=> (st == S_IDLE && !sda_oe));
  // R2: pin mismatch gets no ack
  p_pin_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV_ACK && scl_fall && !ack_half && sh[7:4] == CODE_ARRAY && sh[3:1] != dev_pins)
      |=> !sda_oe);
  // R11: protect-code transfers never reach the page buffer
  p_no_wb_prot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !prot_q);
endmodule

// File: tb/eeprom_tgt_engine_tb.sv
module eeprom_tgt_engine_tb;
  localparam int Q = 8;
  localparam logic [7:0] HW = 8'hAA;  // 1010 101 0
  localparam logic [7:0] HR = 8'hAB;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0, hok = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_oe, hdr_pend, wb_valid, stop_pulse;
  logic [7:0] hdr_byte, wb_addr, wb_data, mem_raddr, mem_rdata;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  logic [7:0] bmem  [256];
  logic [7:0] model [256];
  logic [7:0] ptr_m;
  assign mem_rdata = bmem[mem_raddr];

  eeprom_tgt_engine u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_pins(pins), .cycle_busy(busy), .hdr_ok(hok), .hdr_pend(hdr_pend),
    .hdr_byte(hdr_byte), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .stop_pulse(stop_pulse)
  );

  int wb_cnt = 0, stop_cnt = 0;
  always @(posedge clk) begin
    if (wb_valid) begin
      bmem[wb_addr] <= wb_data;
      wb_cnt++;
    end
    if (stop_pulse) stop_cnt++;
  end

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];
  int   obs_q[$];
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares observed bus results with the expected queue
  initial begin
    exp_t e;
    int o;
    forever begin
      wait (obs_q.size() > 0);
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      check(e.tag, o, e.val);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic t_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic t_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic t_rbit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  // driver: expected ack level (0 = acked) pushed before sending
  task automatic wbyte(logic [7:0] b, int exp_ack, string tag);
    logic a;
    exp_q.push_back('{tag, exp_ack});
    for (int i = 7; i >= 0; i--) t_bit(b[i]);
    t_rbit(a);
    obs_q.push_back(int'(a));
  endtask

  task automatic rbyte(logic [7:0] exp, bit mack, string tag);
    logic [7:0] d;
    logic b;
    exp_q.push_back('{tag, int'(exp)});
    for (int i = 7; i >= 0; i--) begin
      t_rbit(b);
      d[i] = b;
    end
    obs_q.push_back(int'(d));
    t_bit(mack ? 1'b0 : 1'b1);
  endtask

  task automatic page_wr(logic [7:0] addr, int n, logic [7:0] base, string tag);
    logic [3:0] wp;
    wp = addr[3:0];
    t_start();
    wbyte(HW, 0, tag);
    wbyte(addr, 0, tag);
    for (int k = 0; k < n; k++) begin
      wbyte(base + 8'(k), 0, tag);
      model[{addr[7:4], wp}] = base + 8'(k);
      wp = wp + 4'd1;
    end
    ptr_m = {addr[7:4], wp};
    t_stop();
  endtask

  task automatic rand_hdr(logic [7:0] addr, string tag);
    t_start();
    wbyte(HW, 0, tag);
    wbyte(addr, 0, tag);
    t_start();
    wbyte(HR, 0, tag);
    ptr_m = addr;
  endtask

  task automatic rd_next(bit mack, string tag);
    rbyte(model[ptr_m], mack, tag);
    ptr_m = ptr_m + 8'd1;
  endtask

  initial begin
    int s0, w0;
    for (int i = 0; i < 256; i++) begin
      bmem[i]  = 8'(i) ^ 8'hA5;
      model[i] = 8'(i) ^ 8'hA5;
    end
    ptr_m = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check("R12 sda released", int'(sda_oe), 0);
    check("R12 no strobe", int'(wb_valid), 0);
    check("R12 pointer zero", int'(mem_raddr), 0);

    // R5 byte write, R1 stop pulse
    s0 = stop_cnt;
    page_wr(8'h10, 1, 8'h3C, "R5 byte write");
    check("R1 single stop pulse", stop_cnt - s0, 1);

    // R8 random read, R4 MSB first
    rand_hdr(8'h10, "R8 random hdr");
    rd_next(1'b0, "R8 R4 random data");
    t_stop();

    // R7 current-address read
    t_start();
    wbyte(HR, 0, "R7 hdr");
    rd_next(1'b0, "R7 current data");
    t_stop();

    // R6 page wrap on write
    page_wr(8'h1E, 3, 8'hD1, "R6 page write");
    rand_hdr(8'h1E, "R6 readback hdr");
    rd_next(1'b1, "R6 byte 1E");
    rd_next(1'b1, "R6 byte 1F");
    rd_next(1'b0, "R9 crosses page on read");
    t_stop();
    rand_hdr(8'h10, "R6 wrapped hdr");
    rd_next(1'b0, "R6 wrapped byte at 10");
    t_stop();

    // R9 sequential wrap FF->00, then R7 continues after it
    rand_hdr(8'hFE, "R9 seq hdr");
    rd_next(1'b1, "R9 byte FE");
    rd_next(1'b1, "R9 byte FF");
    rd_next(1'b0, "R9 wrapped byte 00");
    t_stop();
    t_start();
    wbyte(HR, 0, "R7 hdr after wrap");
    rd_next(1'b0, "R7 R9 byte 01");
    t_stop();

    // R2 wrong pins
    t_start();
    wbyte(8'hA0, 1, "R2 pin mismatch nack");
    t_stop();

    // R10 busy polling
    busy = 1'b1;
    t_start();
    wbyte(HR, 1, "R10 busy nack");
    t_stop();
    busy = 1'b0;
    t_start();
    wbyte(HR, 0, "R10 ack after busy");
    rd_next(1'b0, "R10 R7 data after poll");
    t_stop();

    // R11 protect code
    hok = 1'b0;
    t_start();
    wbyte(8'h62, 1, "R11 refused nack");
    t_stop();
    hok = 1'b1;
    w0 = wb_cnt;
    t_start();
    wbyte(8'h62, 0, "R11 accepted");
    wbyte(8'h00, 0, "R11 addr byte");
    wbyte(8'h77, 0, "R11 data byte");
    t_stop();
    check("R11 no write strobe", wb_cnt - w0, 0);
    t_start();
    wbyte(8'h63, 0, "R11 status hdr");
    rbyte(8'hFF, 1'b0, "R11 status data");
    t_stop();
    hok = 1'b0;
    t_start();
    wbyte(HR, 0, "R11 pointer hdr");
    rd_next(1'b0, "R11 pointer unchanged");
    t_stop();

    // R1 start mid-byte aborts and restarts, R3 acks verified along the way
    t_start();
    t_bit(1'b1); t_bit(1'b0); t_bit(1'b1); t_bit(1'b0);
    page_wr(8'h40, 1, 8'h5A, "R1 R3 after abort");
    rand_hdr(8'h40, "R1 readback hdr");
    rd_next(1'b0, "R1 byte after abort");
    t_stop();
    check("R3 released at idle", int'(sda_oe), 0);

    wait (obs_q.size() == 0);
    tick(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule